// File: doc/BRIEF.md
# Fractional-Mantissa Floating-Point Multiplier

This block multiplies two floating-point operands. It does not use the IEEE 754 format. Each operand has three fields: a sign bit, a two's-complement exponent and an unsigned mantissa. The mantissa is read as a binary fraction whose most significant bit has weight one half, so a normalized mantissa lies in [0.5, 1.0). The value of an operand is therefore (-1)^sign × (mantissa / 2^MANT_W) × 2^exponent. An operand whose mantissa is all zeros is the value zero.

The block computes four things: the sign as an XOR, the sum of the exponents and the full-width product of the mantissas. The product of two normalized mantissas lies in [0.25, 1.0), so a one-bit left shift with an exponent decrement is the only renormalization ever needed. After that shift the mantissa is truncated to operand width. The block then checks the exponent against the representable range:
- Too large: the result saturates and the overflow flag is set.
- Too small, or either operand zero: the result is forced to a canonical zero and the zero flag is set.

The pipeline has two register stages. The first stage multiplies and the second normalizes and checks. It accepts a new operand pair on every cycle.

Top module: `frac_fmul`

## Requirements
- R1: A result appears on the outputs with `outValid` high exactly two clock cycles after an operand pair is presented with `inValid` high. Back-to-back pairs give back-to-back results, and a cycle with `inValid` low gives `outValid` low two cycles later.
- R2: For a result that is neither zero nor saturated, `outSign` is the XOR of `aSign` and `bSign`.
- R3: When the most significant bit of the full mantissa product is 1, `outMant` is the upper MANT_W bits of the product and `outExp` is `aExp + bExp`. Every non-zero result has `outMant[MANT_W-1] = 1`.
- R4: When the most significant bit of the full mantissa product is 0, the product is shifted left by one bit before the upper MANT_W bits are taken, and `outExp` is `aExp + bExp - 1`.
- R5: When the renormalized exponent exceeds 2^(EXP_W-1)-1, the result saturates and `outZero` stays 0. A renormalized exponent equal to that maximum is a normal result with no overflow. Saturation gives:
  - `outOverflow` = 1
  - `outExp` = 2^(EXP_W-1)-1 (6'h1F by default)
  - `outMant` all ones
  - `outSign` = `aSign` XOR `bSign`
- R6: When either operand mantissa is all zeros, the result is the canonical zero:
  - `outZero` = 1
  - `outOverflow` = 0
  - `outSign` = 0
  - `outMant` = 0
  - `outExp` = -2^(EXP_W-1) (6'h20 by default)
- R7: When the renormalized exponent is below -2^(EXP_W-1), the result is the canonical zero of R6. A renormalized exponent equal to that minimum is a normal result.
- R8: While `rstN` is low, all outputs are 0. This includes `outValid`, and reset acts without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand pair present this cycle |
| aSign | input | 1 | Sign of operand A (1 = negative) |
| aExp | input | EXP_W | Two's-complement exponent of A |
| aMant | input | MANT_W | Fractional mantissa of A |
| bSign | input | 1 | Sign of operand B |
| bExp | input | EXP_W | Two's-complement exponent of B |
| bMant | input | MANT_W | Fractional mantissa of B |
| outValid | output | 1 | Result present this cycle |
| outSign | output | 1 | Result sign |
| outExp | output | EXP_W | Result exponent |
| outMant | output | MANT_W | Result mantissa, truncated |
| outOverflow | output | 1 | Exponent overflow, result saturated |
| outZero | output | 1 | Result is zero |

## Verification
The vector table streams operand pairs back to back and mixes the two renormalization paths:
- Minimum-by-minimum mantissas (0x80 × 0x80) and 0x81 × 0x81 land below one half, which exposes a missing or wrongly directed shift.
- 0xC0 × 0xC0 and 0xFF × 0xFF stay above one half, which separates the unshifted path from the shifted one.

Exponents are set on both sides of each range limit:
- Exactly the maximum after a decrement, and one above.
- Exactly the minimum without a decrement, and one below.

These cases separate the comparison made before renormalization from the one made after it. Zero mantissas, mixed signs and isolated valid pulses show that zero, sign and the valid pipeline are handled apart from the arithmetic.

// File: rtl/frac_fmul_pkg.sv
package frac_fmul_pkg;
  // Strobes from the control pipeline to the datapath registers.
  typedef struct packed {
    logic loadMul;   // capture operands into the multiply stage
    logic loadNorm;  // capture the normalized result into the output stage
  } fmulStrobes_t;
endpackage

// File: rtl/frac_fmul_ctrl.sv
module frac_fmul_ctrl
  import frac_fmul_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output fmulStrobes_t strobes,
  output logic         outValid
);
  logic mulValid;
  logic normValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulValid  <= 1'b0;
      normValid <= 1'b0;
    end else begin
      mulValid  <= inValid;
      normValid <= mulValid;
    end
  end

  assign strobes.loadMul  = inValid;
  assign strobes.loadNorm = mulValid;
  assign outValid         = normValid;
endmodule

// File: rtl/frac_fmul_datapath.sv
module frac_fmul_datapath
  import frac_fmul_pkg::*;
#(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmulStrobes_t      strobes,
  input  logic              aSign,
  input  logic [EXP_W-1:0]  aExp,
  input  logic [MANT_W-1:0] aMant,
  input  logic              bSign,
  input  logic [EXP_W-1:0]  bExp,
  input  logic [MANT_W-1:0] bMant,
  output logic              outSign,
  output logic [EXP_W-1:0]  outExp,
  output logic [MANT_W-1:0] outMant,
  output logic              outOverflow,
  output logic              outZero
);
  localparam int PROD_W = 2 * MANT_W;
  localparam int SUM_W  = EXP_W + 1;
  localparam int ADJ_W  = EXP_W + 2;
  localparam logic [EXP_W-1:0]  EXP_SAT  = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [EXP_W-1:0]  EXP_ZERO = {1'b1, {(EXP_W-1){1'b0}}};
  localparam logic [MANT_W-1:0] MANT_SAT = {MANT_W{1'b1}};

  // ---------------- stage 1: multiply ----------------
  logic              mulSign;
  logic [SUM_W-1:0]  mulExpSum;
  logic [PROD_W-1:0] mulProd;
  logic              mulZeroIn;

  logic [PROD_W-1:0] prodNext;
  logic [SUM_W-1:0]  sumNext;

  assign prodNext = {{MANT_W{1'b0}}, aMant} * {{MANT_W{1'b0}}, bMant};
  assign sumNext  = {aExp[EXP_W-1], aExp} + {bExp[EXP_W-1], bExp};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulSign   <= 1'b0;
      mulExpSum <= '0;
      mulProd   <= '0;
      mulZeroIn <= 1'b0;
    end else if (strobes.loadMul) begin
      mulSign   <= aSign ^ bSign;
      mulExpSum <= sumNext;
      mulProd   <= prodNext;
      mulZeroIn <= (aMant == '0) || (bMant == '0);
    end
  end

  // ---------------- stage 2: normalize and check ----------------
  logic              needShift;
  logic [MANT_W-1:0] normMant;
  logic [ADJ_W-1:0]  expAdj;
  logic              outOfRange;
  logic              expHigh;
  logic              expLow;

  assign needShift = ~mulProd[PROD_W-1];
  assign normMant  = needShift ? mulProd[PROD_W-2 -: MANT_W]
                               : mulProd[PROD_W-1 -: MANT_W];
  assign expAdj    = {mulExpSum[SUM_W-1], mulExpSum}
                   - {{(ADJ_W-1){1'b0}}, needShift};
  // The adjusted exponent fits EXP_W bits only when its top three bits agree.
  assign outOfRange = !((expAdj[ADJ_W-1:EXP_W-1] == '0) ||
                        (expAdj[ADJ_W-1:EXP_W-1] == '1));
  assign expHigh = outOfRange && !expAdj[ADJ_W-1];
  assign expLow  = outOfRange &&  expAdj[ADJ_W-1];

  logic              nxtSign;
  logic [EXP_W-1:0]  nxtExp;
  logic [MANT_W-1:0] nxtMant;
  logic              nxtOvf;
  logic              nxtZero;

  always_comb begin
    nxtSign = mulSign;
    nxtExp  = expAdj[EXP_W-1:0];
    nxtMant = normMant;
    nxtOvf  = 1'b0;
    nxtZero = 1'b0;
    if (mulZeroIn || expLow) begin
      nxtSign = 1'b0;
      nxtExp  = EXP_ZERO;
      nxtMant = '0;
      nxtZero = 1'b1;
    end else if (expHigh) begin
      nxtExp  = EXP_SAT;
      nxtMant = MANT_SAT;
      nxtOvf  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSign     <= 1'b0;
      outExp      <= '0;
      outMant     <= '0;
      outOverflow <= 1'b0;
      outZero     <= 1'b0;
    end else if (strobes.loadNorm) begin
      outSign     <= nxtSign;
      outExp      <= nxtExp;
      outMant     <= nxtMant;
      outOverflow <= nxtOvf;
      outZero     <= nxtZero;
    end
  end
endmodule

// File: rtl/frac_fmul.sv
module frac_fmul
  import frac_fmul_pkg::*;
#(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              aSign,
  input  logic [EXP_W-1:0]  aExp,
  input  logic [MANT_W-1:0] aMant,
  input  logic              bSign,
  input  logic [EXP_W-1:0]  bExp,
  input  logic [MANT_W-1:0] bMant,
  output logic              outValid,
  output logic              outSign,
  output logic [EXP_W-1:0]  outExp,
  output logic [MANT_W-1:0] outMant,
  output logic              outOverflow,
  output logic              outZero
);
  fmulStrobes_t strobes;

  frac_fmul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  frac_fmul_datapath #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .aSign       (aSign),
    .aExp        (aExp),
    .aMant       (aMant),
    .bSign       (bSign),
    .bExp        (bExp),
    .bMant       (bMant),
    .outSign     (outSign),
    .outExp      (outExp),
    .outMant     (outMant),
    .outOverflow (outOverflow),
    .outZero     (outZero)
  );
endmodule

// File: rtl/frac_fmul_checker.sv
module frac_fmul_checker #(
  parameter int MANT_W = 8,
  parameter int EXP_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              aSign,
  input logic [MANT_W-1:0] aMant,
  input logic              bSign,
  input logic [MANT_W-1:0] bMant,
  input logic              outValid,
  input logic              outSign,
  input logic [EXP_W-1:0]  outExp,
  input logic [MANT_W-1:0] outMant,
  input logic              outOverflow,
  input logic              outZero
);
  localparam logic [EXP_W-1:0] EXP_SAT  = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [EXP_W-1:0] EXP_ZERO = {1'b1, {(EXP_W-1){1'b0}}};

  // Cycles since reset, saturating at 2, so $past(...,2) never reaches into reset.
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= 2'd0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> (outValid == $past(inValid, 2))); // R1

  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2 && outValid && !outZero) |->
      (outSign == $past(aSign ^ bSign, 2))); // R2

  AST_NORMALIZED: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outZero) |-> outMant[MANT_W-1]); // R3

  AST_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOverflow) |->
      (outExp == EXP_SAT && outMant == {MANT_W{1'b1}} && !outZero)); // R5

  AST_ZERO_FORM: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outZero) |->
      (outExp == EXP_ZERO && outMant == '0 && !outSign && !outOverflow)); // R6

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2 && outValid && $past((aMant == '0) || (bMant == '0), 2))
      |-> outZero); // R6
endmodule

bind frac_fmul frac_fmul_checker #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .aSign       (aSign),
  .aMant       (aMant),
  .bSign       (bSign),
  .bMant       (bMant),
  .outValid    (outValid),
  .outSign     (outSign),
  .outExp      (outExp),
  .outMant     (outMant),
  .outOverflow (outOverflow),
  .outZero     (outZero)
);

// File: tb/frac_fmul_test.sv
`timescale 1ns/1ps
module frac_fmul_test;
  localparam int MANT_W = 8;
  localparam int EXP_W  = 6;
  localparam int NVEC   = 12;
  localparam int VEC_W  = 47;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic              aSign, bSign;
  logic [EXP_W-1:0]  aExp, bExp;
  logic [MANT_W-1:0] aMant, bMant;
  logic              outValid, outSign, outOverflow, outZero;
  logic [EXP_W-1:0]  outExp;
  logic [MANT_W-1:0] outMant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  frac_fmul #(.MANT_W(MANT_W), .EXP_W(EXP_W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .aSign(aSign), .aExp(aExp), .aMant(aMant),
    .bSign(bSign), .bExp(bExp), .bMant(bMant),
    .outValid(outValid), .outSign(outSign), .outExp(outExp),
    .outMant(outMant), .outOverflow(outOverflow), .outZero(outZero)
  );

  // {aS,aE,aM,bS,bE,bM} then expected {sign,exp,mant,ovf,zero}
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {1'b0,6'h03,8'h80, 1'b0,6'h02,8'h80,  1'b0,6'h04,8'h80,1'b0,1'b0},
    {1'b0,6'h01,8'hFF, 1'b1,6'h01,8'hFF,  1'b1,6'h02,8'hFE,1'b0,1'b0},
    {1'b1,6'h3D,8'hC0, 1'b1,6'h00,8'hC0,  1'b0,6'h3D,8'h90,1'b0,1'b0},
    {1'b1,6'h0A,8'hA0, 1'b0,6'h3C,8'hB0,  1'b1,6'h05,8'hDC,1'b0,1'b0},
    {1'b0,6'h1F,8'h80, 1'b0,6'h01,8'hFF,  1'b0,6'h1F,8'hFF,1'b0,1'b0},
    {1'b1,6'h1F,8'hC0, 1'b0,6'h01,8'hC0,  1'b1,6'h1F,8'hFF,1'b1,1'b0},
    {1'b1,6'h20,8'h80, 1'b1,6'h00,8'h80,  1'b0,6'h20,8'h00,1'b0,1'b1},
    {1'b0,6'h20,8'hC0, 1'b0,6'h00,8'hC0,  1'b0,6'h20,8'h90,1'b0,1'b0},
    {1'b1,6'h05,8'h00, 1'b0,6'h03,8'hAB,  1'b0,6'h20,8'h00,1'b0,1'b1},
    {1'b0,6'h30,8'h80, 1'b0,6'h30,8'h80,  1'b0,6'h20,8'h00,1'b0,1'b1},
    {1'b0,6'h14,8'hFF, 1'b0,6'h14,8'hFF,  1'b0,6'h1F,8'hFF,1'b1,1'b0},
    {1'b0,6'h00,8'h81, 1'b0,6'h00,8'h81,  1'b0,6'h3F,8'h82,1'b0,1'b0}
  };
  string tags [NVEC] = '{"R4","R2","R3","R4","R5","R5",
                         "R7","R7","R6","R7","R5","R4"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] outWord();
    return {outSign, outExp, outMant, outOverflow, outZero};
  endfunction

  task automatic drive(input logic [VEC_W-1:0] v, input logic vld);
    {aSign, aExp, aMant, bSign, bExp, bMant} = v[VEC_W-1:17];
    inValid = vld;
  endtask

  initial begin
    rstN = 1'b0;
    drive('0, 1'b0);
    repeat (3) @(negedge clk);
    check("R8 reset valid", {31'd0, outValid}, 32'd0);
    check("R8 reset outputs", {15'd0, outWord()}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 valid after release", {31'd0, outValid}, 32'd0);

    // stream: output for vector j-2 visible at the negedge where vector j is driven
    for (int j = 0; j < NVEC + 2; j++) begin
      if (j >= 2) begin
        check("R1 streamed valid", {31'd0, outValid}, 32'd1);
        check(tags[j-2], {15'd0, outWord()}, {15'd0, VECS[j-2][16:0]});
      end
      if (j < NVEC) drive(VECS[j], 1'b1);
      else drive('0, 1'b0);
      @(negedge clk);
    end
    check("R1 idle gives no valid", {31'd0, outValid}, 32'd0);

    // isolated pulse: valid exactly two cycles later, for one cycle
    drive(VECS[1], 1'b1);
    @(negedge clk);
    drive('0, 1'b0);
    check("R1 not after one cycle", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    check("R1 pulse valid", {31'd0, outValid}, 32'd1);
    check("R2 pulse result", {15'd0, outWord()}, {15'd0, VECS[1][16:0]});
    @(negedge clk);
    check("R1 pulse ends", {31'd0, outValid}, 32'd0);

    // asynchronous reset in the middle of a stream
    drive(VECS[5], 1'b1);
    repeat (3) @(negedge clk);
    check("R5 before reset", {15'd0, outWord()}, {15'd0, VECS[5][16:0]});
    rstN = 1'b0;
    #1;
    check("R8 async valid", {31'd0, outValid}, 32'd0);
    check("R8 async outputs", {15'd0, outWord()}, 32'd0);
    drive('0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule